// File: doc/BRIEF.md
# Configurable Fine-Grain Logic Cell

This block is a single cell of a fine-grained programmable logic array. Each of its four neighbours (north, south, east, west) sends it one A-class bit and one B-class bit. The cell sends back one A-class bit and one B-class bit, and the same pair goes to all four neighbours. Static configuration inputs pick one neighbour (or a constant 1) for the A path and, independently, one for the B path.

Each picked bit is gated by a second term in an AND gate. On the A side that term is a constant 1 or one of the local-bus lines. On the B side it is either a pass-through 1 or a blocking 0. A two-bit function state then sets both outputs at once. The four functions are: pass straight, cross over, XOR with NAND, and registered XOR with AND.

One cell configured with the A side gated by a bus line and the B side passed through computes (A AND bus) XOR B. The cell's only storage element is a single flip-flop. It runs on an external clock and has an asynchronous active-low clear.

Top module: `lcell_top`

## Requirements
- R1: Source selects `cfg_a_sel` and `cfg_b_sel` are decoded independently. Code 0 picks index 0 (north), 1 picks index 1 (south), 2 picks index 2 (east) and 3 picks index 3 (west) of `a_in`/`b_in`. Every code from 4 to 7 picks a constant 1.
- R2: The left gate result is the picked A bit ANDed with a term chosen by `cfg_lterm`. Code 0 gives constant 1, code 1 gives `bus_in[0]`, code 2 gives `bus_in[1]`, and code 3 gives constant 0.
- R3: The right gate result is the picked B bit ANDed with 1 when `cfg_rterm` is 0 and with 0 when `cfg_rterm` is 1.
- R4: With `cfg_state` = 0, `a_out` equals the left gate result and `b_out` equals the right gate result.
- R5: With `cfg_state` = 1, `a_out` equals the right gate result and `b_out` equals the left gate result.
- R6: With `cfg_state` = 2, `a_out` is the XOR and `b_out` is the NAND of the two gate results.
- R7: With `cfg_state` = 3, `b_out` is the AND of the two gate results. `a_out` is the XOR of the two gate results as sampled at the most recent rising edge of `clk`.
- R8: While `rst_n` is low, the flip-flop is held at 0, and this takes effect without waiting for a clock edge. With `cfg_state` = 3, `a_out` reads 0 from reset until the first rising edge after release.
- R9: The flip-flop samples the XOR at every rising edge in every state. Switching into state 3 therefore shows the value captured at the last edge, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell flip-flop |
| rst_n | input | 1 | Asynchronous active-low clear of the flip-flop |
| a_in | input | 4 | A-class bits from neighbours, index 0..3 = N, S, E, W |
| b_in | input | 4 | B-class bits from neighbours, index 0..3 = N, S, E, W |
| bus_in | input | 2 | Local-bus lines available to the left gate |
| cfg_a_sel | input | 3 | A source select |
| cfg_b_sel | input | 3 | B source select |
| cfg_lterm | input | 2 | Left gate second-term select |
| cfg_rterm | input | 1 | Right gate block (1) / pass (0) |
| cfg_state | input | 2 | Function state 0..3 |
| a_out | output | 1 | A-class output to all neighbours |
| b_out | output | 1 | B-class output to all neighbours |

## Verification
The assertions assume that configuration and data inputs change only away from the rising clock edge. They also assume that every input is driven to a defined value from time zero, because the reset property fires during reset without a disable. The swap property further assumes that data and select inputs stay unchanged across the cycle in which the state moves from 0 to 1. The bench keeps to these assumptions by driving everything on the falling edge and holding inputs fixed across each rising edge. It also loads defined values before the first edge.

// File: rtl/lcell_pkg.sv
// Package: shared constants and types for the fine-grain logic cell.
// Assumes: neighbour order N, S, E, W maps to vector index 0..3.
package lcell_pkg;

    localparam int NDIR      = 4;  // neighbours per cell
    localparam int SRC_SEL_W = 3;  // width of a neighbour source select

    // Function state steering both outputs together
    typedef enum logic [1:0] {
        FN_PASS  = 2'd0,
        FN_SWAP  = 2'd1,
        FN_XNAND = 2'd2,
        FN_REG   = 2'd3
    } fn_state_t;

endpackage

// File: rtl/lcell_src_mux.sv
// Module: lcell_src_mux
// Picks one of NIN neighbour bits by index; any code at or above NIN
// yields constant 1. Purely combinational.
// Assumes: SEL_W is wide enough to encode at least NIN+1 codes.
module lcell_src_mux #(
    parameter int NIN   = 4,
    parameter int SEL_W = 3
) (
    input  logic [NIN-1:0]   din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);

    // Decode select: default constant 1, override on a matching index
    always_comb begin
        dout = 1'b1;
        for (int i = 0; i < NIN; i++) begin
            if (sel == SEL_W'(i)) dout = din[i];
        end
    end

endmodule

// File: rtl/lcell_gate_stage.sv
// Module: lcell_gate_stage
// Two upstream AND gates. Left: picked A bit AND a term chosen from
// constant 1 (code 0), bus line k-1 (code k, 1..NBUS), else constant 0.
// Right: picked B bit AND (block ? 0 : 1).
// Assumes: LSEL_W can encode NBUS+1 codes.
module lcell_gate_stage #(
    parameter int NBUS   = 2,
    parameter int LSEL_W = 2
) (
    input  logic              a_pick,
    input  logic              b_pick,
    input  logic [NBUS-1:0]   bus_in,
    input  logic [LSEL_W-1:0] lterm_sel,
    input  logic              rterm_blk,
    output logic              left_q,
    output logic              right_q
);

    logic lterm;

    // Left second-term selector
    always_comb begin
        lterm = 1'b0;
        if (lterm_sel == '0) lterm = 1'b1;
        for (int k = 0; k < NBUS; k++) begin
            if (lterm_sel == LSEL_W'(k + 1)) lterm = bus_in[k];
        end
    end

    // Both upstream AND gates
    always_comb begin
        left_q  = a_pick & lterm;
        right_q = b_pick & ~rterm_blk;
    end

endmodule

// File: rtl/lcell_func_stage.sv
// Module: lcell_func_stage
// Output steering by the function state, plus the cell flip-flop that
// samples the XOR of the gate results at every rising clock edge.
// Assumes: rst_n is asynchronous and active low.
module lcell_func_stage
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      left_q,
    input  logic      right_q,
    input  fn_state_t state,
    output logic      a_out,
    output logic      b_out
);

    logic x_val;
    logic reg_q;

    assign x_val = left_q ^ right_q;

    // Cell flip-flop: captures XOR each edge, cleared asynchronously
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= 1'b0;
        else        reg_q <= x_val;
    end

    // Tandem output multiplexers driven by one state
    always_comb begin
        unique case (state)
            FN_PASS:  begin a_out = left_q;  b_out = right_q;            end
            FN_SWAP:  begin a_out = right_q; b_out = left_q;             end
            FN_XNAND: begin a_out = x_val;   b_out = ~(left_q & right_q); end
            default:  begin a_out = reg_q;   b_out = left_q & right_q;   end
        endcase
    end

endmodule

// File: rtl/lcell_top.sv
// Module: lcell_top
// One fine-grain logic cell: two independent neighbour source muxes,
// two upstream AND gates and a state-steered output stage.
// Assumes: configuration inputs are static during normal operation.
module lcell_top
    import lcell_pkg::*;
#(
    parameter int NBUS   = 2,
    parameter int SEL_W  = SRC_SEL_W,
    parameter int LSEL_W = $clog2(NBUS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIR-1:0]   a_in,
    input  logic [NDIR-1:0]   b_in,
    input  logic [NBUS-1:0]   bus_in,
    input  logic [SEL_W-1:0]  cfg_a_sel,
    input  logic [SEL_W-1:0]  cfg_b_sel,
    input  logic [LSEL_W-1:0] cfg_lterm,
    input  logic              cfg_rterm,
    input  logic [1:0]        cfg_state,
    output logic              a_out,
    output logic              b_out
);

    logic a_pick, b_pick;
    logic left_q, right_q;
    fn_state_t state;

    assign state = fn_state_t'(cfg_state);

    lcell_src_mux #(.NIN(NDIR), .SEL_W(SEL_W)) u_amux (
        .din(a_in), .sel(cfg_a_sel), .dout(a_pick)
    );

    lcell_src_mux #(.NIN(NDIR), .SEL_W(SEL_W)) u_bmux (
        .din(b_in), .sel(cfg_b_sel), .dout(b_pick)
    );

    lcell_gate_stage #(.NBUS(NBUS), .LSEL_W(LSEL_W)) u_gates (
        .a_pick(a_pick), .b_pick(b_pick), .bus_in(bus_in),
        .lterm_sel(cfg_lterm), .rterm_blk(cfg_rterm),
        .left_q(left_q), .right_q(right_q)
    );

    lcell_func_stage u_func (
        .clk(clk), .rst_n(rst_n), .left_q(left_q), .right_q(right_q),
        .state(state), .a_out(a_out), .b_out(b_out)
    );

endmodule

// File: rtl/lcell_checker.sv
// Module: lcell_checker
// Port-level properties of the logic cell, bound into lcell_top.
// Assumes: inputs change only away from the rising clock edge.
module lcell_checker #(
    parameter int NBUS   = 2,
    parameter int SEL_W  = 3,
    parameter int LSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        a_in,
    input logic [3:0]        b_in,
    input logic [NBUS-1:0]   bus_in,
    input logic [SEL_W-1:0]  cfg_a_sel,
    input logic [SEL_W-1:0]  cfg_b_sel,
    input logic [LSEL_W-1:0] cfg_lterm,
    input logic              cfg_rterm,
    input logic [1:0]        cfg_state,
    input logic              a_out,
    input logic              b_out
);

    // Reset holds the registered A output low in state 3
    assert_reset_clears_reg_R8: assert property (@(posedge clk)
        (!rst_n && cfg_state == 2'd3) |-> !a_out);

    // Both gate results high in state 3 means a zero XOR is captured
    assert_reg_captures_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == 2'd3 && b_out) |=> (cfg_state != 2'd3 || !a_out));

    // Moving from state 0 to 1 with steady inputs swaps the outputs
    assert_swap_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == 2'd1 && $past(cfg_state) == 2'd0 && $stable(a_in) &&
         $stable(b_in) && $stable(bus_in) && $stable(cfg_a_sel) &&
         $stable(cfg_b_sel) && $stable(cfg_lterm) && $stable(cfg_rterm))
        |-> (a_out == $past(b_out) && b_out == $past(a_out)));

    // XOR high with NAND low cannot occur in state 2
    assert_xor_nand_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == 2'd2) |-> !(a_out && !b_out));

    // Blocking the right gate forces the pass-state B output low
    assert_rterm_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == 2'd0 && cfg_rterm) |-> !b_out);

    // Constant-1 source with constant-1 term drives A high in state 0
    assert_const_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == 2'd0 && cfg_a_sel >= SEL_W'(4) && cfg_lterm == '0) |-> a_out);

endmodule

bind lcell_top lcell_checker #(.NBUS(NBUS), .SEL_W(SEL_W), .LSEL_W(LSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .bus_in(bus_in),
    .cfg_a_sel(cfg_a_sel), .cfg_b_sel(cfg_b_sel), .cfg_lterm(cfg_lterm),
    .cfg_rterm(cfg_rterm), .cfg_state(cfg_state), .a_out(a_out), .b_out(b_out)
);

// File: tb/tb_lcell_top.sv
module tb_lcell_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [1:0] bus_in = '0;
    logic [2:0] cfg_a_sel = '0;
    logic [2:0] cfg_b_sel = '0;
    logic [1:0] cfg_lterm = '0;
    logic       cfg_rterm = 1'b0;
    logic [1:0] cfg_state = 2'd3;
    logic       a_out, b_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;  // 125 MHz

    lcell_top dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .bus_in(bus_in),
        .cfg_a_sel(cfg_a_sel), .cfg_b_sel(cfg_b_sel), .cfg_lterm(cfg_lterm),
        .cfg_rterm(cfg_rterm), .cfg_state(cfg_state), .a_out(a_out), .b_out(b_out)
    );

    // {a_sel, b_sel, lterm, rterm, state, a_in, b_in, bus, exp_a, exp_b}
    localparam logic [22:0] TBL [8] = '{
        {3'd0, 3'd0, 2'd0, 1'b0, 2'd0, 4'b0001, 4'b0001, 2'b00, 1'b1, 1'b1}, // R1 R4
        {3'd1, 3'd2, 2'd0, 1'b0, 2'd1, 4'b0010, 4'b0000, 2'b00, 1'b0, 1'b1}, // R5
        {3'd3, 3'd3, 2'd0, 1'b0, 2'd2, 4'b1000, 4'b0000, 2'b00, 1'b1, 1'b1}, // R6
        {3'd3, 3'd3, 2'd0, 1'b0, 2'd2, 4'b1000, 4'b1000, 2'b00, 1'b0, 1'b0}, // R6
        {3'd4, 3'd4, 2'd1, 1'b0, 2'd0, 4'b0000, 4'b0000, 2'b01, 1'b1, 1'b1}, // R1 R2
        {3'd4, 3'd4, 2'd2, 1'b0, 2'd0, 4'b0000, 4'b0000, 2'b01, 1'b0, 1'b1}, // R2
        {3'd4, 3'd7, 2'd3, 1'b1, 2'd0, 4'b1111, 4'b1111, 2'b11, 1'b0, 1'b0}, // R2 R3
        {3'd2, 3'd1, 2'd1, 1'b0, 2'd2, 4'b0100, 4'b0010, 2'b11, 1'b0, 1'b0}  // R2 R6
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference gate results from R1..R3
    function automatic logic [1:0] ref_xy(input logic [2:0] as, input logic [2:0] bs,
                                          input logic [1:0] lt, input logic rt,
                                          input logic [3:0] ai, input logic [3:0] bi,
                                          input logic [1:0] bu);
        logic ap, bp, lterm;
        ap = (as < 3'd4) ? ai[as[1:0]] : 1'b1;
        bp = (bs < 3'd4) ? bi[bs[1:0]] : 1'b1;
        case (lt)
            2'd0: lterm = 1'b1;
            2'd1: lterm = bu[0];
            2'd2: lterm = bu[1];
            default: lterm = 1'b0;
        endcase
        return {ap & lterm, bp & ~rt};
    endfunction

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [1:0] xy;
        // R8: reset state, register cleared while held in reset
        #2;
        check("R8 reset a_out", a_out, 1'b0);
        @(posedge clk); @(posedge clk); #1;
        check("R8 reset held", a_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table of directed combinational vectors
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {cfg_a_sel, cfg_b_sel, cfg_lterm, cfg_rterm, cfg_state,
             a_in, b_in, bus_in} = TBL[i][22:2];
            #1;
            check("R1-vec a_out", a_out, TBL[i][1]);
            check("R1-vec b_out", b_out, TBL[i][0]);
        end

        // Sweep selects and combinational states against the model (R1..R6)
        for (int as = 0; as < 5; as++)
            for (int bs = 0; bs < 5; bs++)
                for (int lt = 0; lt < 4; lt++)
                    for (int rt = 0; rt < 2; rt++)
                        for (int st = 0; st < 3; st++) begin
                            @(negedge clk);
                            cfg_a_sel = 3'(as); cfg_b_sel = 3'(bs);
                            cfg_lterm = 2'(lt); cfg_rterm = 1'(rt);
                            cfg_state = 2'(st);
                            a_in = 4'($urandom); b_in = 4'($urandom);
                            bus_in = 2'($urandom);
                            xy = ref_xy(cfg_a_sel, cfg_b_sel, cfg_lterm, cfg_rterm,
                                        a_in, b_in, bus_in);
                            #1;
                            case (st)
                                0: begin check("R4 a", a_out, xy[1]); check("R4 b", b_out, xy[0]); end
                                1: begin check("R5 a", a_out, xy[0]); check("R5 b", b_out, xy[1]); end
                                default: begin
                                    check("R6 a", a_out, xy[1] ^ xy[0]);
                                    check("R6 b", b_out, ~(xy[1] & xy[0]));
                                end
                            endcase
                        end

        // R7: registered state, one-cycle latency on A
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cfg_state = 2'd3;
            cfg_a_sel = 3'($urandom_range(0, 4)); cfg_b_sel = 3'($urandom_range(0, 4));
            cfg_lterm = 2'($urandom); cfg_rterm = 1'($urandom);
            a_in = 4'($urandom); b_in = 4'($urandom); bus_in = 2'($urandom);
            xy = ref_xy(cfg_a_sel, cfg_b_sel, cfg_lterm, cfg_rterm, a_in, b_in, bus_in);
            #1;
            check("R7 b_out and", b_out, xy[1] & xy[0]);
            @(posedge clk); #1;
            check("R7 a_out reg", a_out, xy[1] ^ xy[0]);
        end

        // R9: register samples in state 0, visible on entry to state 3
        @(negedge clk);
        cfg_state = 2'd0; cfg_a_sel = 3'd4; cfg_b_sel = 3'd4;
        cfg_lterm = 2'd0; cfg_rterm = 1'b1;       // x=1, y=0
        @(posedge clk);
        @(negedge clk);
        cfg_rterm = 1'b0; cfg_state = 2'd3;       // x=1, y=1 now
        #1;
        check("R9 captured in state 0", a_out, 1'b1);
        check("R7 b_out and", b_out, 1'b1);
        @(posedge clk); #1;
        check("R9 next capture", a_out, 1'b0);

        // R8: asynchronous clear mid-run and hold until first edge after release
        @(negedge clk);
        cfg_rterm = 1'b1;                          // xor = 1
        @(posedge clk); #1;
        check("R7 set before reset", a_out, 1'b1);
        #1 rst_n = 1'b0;
        #1;
        check("R8 async clear", a_out, 1'b0);
        @(posedge clk); #1;
        check("R8 held in reset", a_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 after release", a_out, 1'b0);
        @(posedge clk); #1;
        check("R8 first edge", a_out, 1'b1);

        finish_run();
    end

endmodule